// File: doc/BRIEF.md
# SMBus Register Slave for a Multichannel Current Monitor

This block is the host-facing serial port of a current monitor. It watches SCL and SDA through synchronisers on a fast system clock and recognises START, repeated START and STOP conditions. It serves three transaction shapes: Write Byte, Read Byte (command byte, repeated START, one data byte) and Receive Byte (a read that reuses the last command code). Its only drive onto the bus is an open-drain pull-down enable for SDA.

Behind the port sits a command-indexed byte register file. It holds control, two delay settings and four overcurrent thresholds. It also presents the monitor's live status byte, the averaged ADC bytes and fixed identification bytes. Every accepted write and every completed access to the status code is reported to the monitoring logic as a one-cycle pulse, so that logic can apply its own clear and reset side effects.

When the monitor raises an alert request and alerting is enabled, the block also answers the Alert Response Address. It sends its own address while checking the bus bit by bit, and reports a win with a pulse.

Top module: `cmon_smb_slave`

## Requirements
- R1: After reset the control byte is 0Ch, the overcurrent delay byte is 04h, the shutdown delay byte is 14h, all four thresholds are D1h, SDA is not driven, and the command pointer is 00h, so a Receive Byte returns the status input.
- R2: The slave ACKs only its own 7-bit address, and the Alert Response Address 0001100 with R when it is armed. Any other address, including the general call 0000000, is NACKed.
- R3: Command codes 00h to 0Eh are ACKed. A higher code is NACKed but still becomes the command pointer, and any read through it returns FFh.
- R4: Write Byte to code 00h, 01h–03h or 08h–0Bh gives one wr_stb_o pulse carrying the low 4 code bits and the data byte. Codes 01h–03h and 08h–0Bh also update their register; threshold n sits at code 08h+n and in thr_o bits [8n+7:8n]. Writes to 04h–07h and 0Ch–0Eh change nothing and give no strobe.
- R5: Read Byte returns the addressed byte MSB first: 00h is status_i, 04h+n is ADC byte n (00h when n >= NCH), 0Ch is {00001, REV}, 0Dh is {00, YEAR} and 0Eh is {00, WEEK}.
- R6: Receive Byte returns the byte of the most recently sent command code, valid or not.
- R7: Each completed write to code 00h, and each data byte read from code 00h, gives one stat_acc_o pulse.
- R8: When control bit 3 is 1 and alert_req_i is 1, a read of the Alert Response Address is ACKed. The reply is {own address, 1}, and a win gives one ara_won_o pulse. If either condition is 0, the address is NACKed.
- R9: While replying to the Alert Response Address, if a bit the slave leaves high reads back low, it releases SDA for the rest of the transaction and gives no ara_won_o pulse.
- R10: If SCL stays low for TIMEOUT_CYC cycles during a transaction, the slave releases SDA and returns to idle, and the next START is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| own_addr_i | input | 7 | Static 7-bit slave address |
| alert_req_i | input | 1 | Monitor requests alert service |
| status_i | input | 8 | Live status byte served at code 00h |
| adc_i | input | NCH*8 | Averaged ADC bytes, channel n at [8n+7:8n] |
| ctrl_o | output | 8 | Control byte (bit 3 alert enable) |
| ocd_o | output | 8 | Overcurrent delay byte |
| sdd_o | output | 8 | Shutdown delay byte |
| thr_o | output | 32 | Four threshold bytes |
| wr_stb_o | output | 1 | One-cycle write strobe |
| wr_code_o | output | 4 | Code of the strobed write |
| wr_data_o | output | 8 | Data of the strobed write |
| stat_acc_o | output | 1 | One-cycle status access pulse |
| ara_won_o | output | 1 | One-cycle alert arbitration win pulse |

## Verification
The bench builds the slave with NCH=2, so ADC codes 06h and 07h must read 00h while thresholds 3 and 4 remain writable. TIMEOUT_CYC is set to 300, which puts the stuck-low abort within a short run. The own address is 34h, and the bench puts a rival responder at 30h on the wired-AND line. The two reply bytes first differ at bit 3, so a lost arbitration happens at a known bit and the line then carries the rival's byte.

// File: rtl/cmon_smb_pkg.sv
package cmon_smb_pkg;

   localparam int            MAX_CH     = 4;
   localparam logic [6:0]    ARA_ADDR   = 7'h0C;
   localparam logic [7:0]    LAST_CODE  = 8'h0E;
   localparam int            ALERT_BIT  = 3;

   localparam logic [7:0]    C_STATUS   = 8'h00;
   localparam logic [7:0]    C_CTRL     = 8'h01;
   localparam logic [7:0]    C_OCD      = 8'h02;
   localparam logic [7:0]    C_SDD      = 8'h03;

   localparam logic [7:0]    RST_CTRL   = 8'h0C;
   localparam logic [7:0]    RST_OCD    = 8'h04;
   localparam logic [7:0]    RST_SDD    = 8'h14;
   localparam logic [7:0]    RST_THR    = 8'hD1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_CMD,
      ST_WDATA,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_SKIP
   } bus_st_e;

endpackage

// File: rtl/cmon_pin_sync.sv
module cmon_pin_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] sync_o,
   output logic [W-1:0] last_o
);

   initial begin
      assert (STAGES >= 2) else $error("cmon_pin_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain_q [STAGES];
   logic [W-1:0] last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
         last_q <= '1;
      end else begin
         chain_q[0] <= din;
         for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
         last_q <= chain_q[STAGES-1];
      end
   end

   assign sync_o = chain_q[STAGES-1];
   assign last_o = last_q;

endmodule

// File: rtl/cmon_smb_fsm.sv
module cmon_smb_fsm
   import cmon_smb_pkg::*;
#(
   parameter int TIMEOUT_CYC = 7_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_s,
   input  logic       scl_p,
   input  logic       sda_s,
   input  logic       sda_p,
   input  logic [6:0] own_addr,
   input  logic       ara_armed,
   input  logic [7:0] rd_data,
   output logic       sda_oe,
   output logic [7:0] cmd_ptr,
   output logic       wr_en,
   output logic [7:0] wr_data,
   output logic       stat_acc,
   output logic       ara_won
);

   localparam int              TMO_W    = $clog2(TIMEOUT_CYC + 1);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TIMEOUT_CYC - 1);

   initial begin
      assert (TIMEOUT_CYC > 1) else $error("cmon_smb_fsm: TIMEOUT_CYC too small");
   end

   bus_st_e          st_q, nxt_q;
   logic [3:0]       cnt_q;
   logic [7:0]       sh_q;
   logic [7:0]       cmd_q;
   logic             oe_q;
   logic             tx_ara_q;
   logic             macked_q;
   logic             wr_q, stat_q, won_q;
   logic [7:0]       wdat_q;
   logic [TMO_W-1:0] tmo_q;

   logic start_ev, stop_ev, rise, fall, tmo_hit;
   logic [7:0] tx_byte;

   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;
   assign rise     = scl_s & ~scl_p;
   assign fall     = ~scl_s & scl_p;
   assign tmo_hit  = (st_q != ST_IDLE) && !scl_s && (tmo_q == TMO_LAST);
   assign tx_byte  = tx_ara_q ? {own_addr, 1'b1} : rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmo_q <= '0;
      end else if (st_q == ST_IDLE || scl_s || tmo_hit) begin
         tmo_q <= '0;
      end else begin
         tmo_q <= tmo_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         nxt_q    <= ST_IDLE;
         cnt_q    <= '0;
         sh_q     <= '0;
         cmd_q    <= C_STATUS;
         oe_q     <= 1'b0;
         tx_ara_q <= 1'b0;
         macked_q <= 1'b0;
         wr_q     <= 1'b0;
         stat_q   <= 1'b0;
         won_q    <= 1'b0;
         wdat_q   <= '0;
      end else begin
         wr_q   <= 1'b0;
         stat_q <= 1'b0;
         won_q  <= 1'b0;
         if (tmo_hit) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else if (start_ev) begin
            st_q  <= ST_ADDR;
            cnt_q <= '0;
            oe_q  <= 1'b0;
         end else if (stop_ev) begin
            st_q <= ST_IDLE;
            oe_q <= 1'b0;
         end else begin
            unique case (st_q)
               ST_ADDR, ST_CMD, ST_WDATA: begin
                  if (rise) begin
                     sh_q  <= {sh_q[6:0], sda_s};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (fall && cnt_q == 4'd8) begin
                     if (st_q == ST_ADDR) begin
                        if (sh_q[7:1] == own_addr) begin
                           oe_q     <= 1'b1;
                           st_q     <= ST_ACK;
                           nxt_q    <= sh_q[0] ? ST_TX : ST_CMD;
                           tx_ara_q <= 1'b0;
                        end else if (sh_q[7:1] == ARA_ADDR && sh_q[0] && ara_armed) begin
                           oe_q     <= 1'b1;
                           st_q     <= ST_ACK;
                           nxt_q    <= ST_TX;
                           tx_ara_q <= 1'b1;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else if (st_q == ST_CMD) begin
                        cmd_q <= sh_q;
                        if (sh_q <= LAST_CODE) begin
                           oe_q  <= 1'b1;
                           st_q  <= ST_ACK;
                           nxt_q <= ST_WDATA;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end else begin
                        oe_q   <= 1'b1;
                        st_q   <= ST_ACK;
                        nxt_q  <= ST_SKIP;
                        wr_q   <= 1'b1;
                        wdat_q <= sh_q;
                        stat_q <= (cmd_q == C_STATUS);
                     end
                  end
               end
               ST_ACK: begin
                  if (fall) begin
                     cnt_q <= '0;
                     st_q  <= nxt_q;
                     if (nxt_q == ST_TX) begin
                        sh_q <= tx_byte;
                        oe_q <= ~tx_byte[7];
                     end else begin
                        oe_q <= 1'b0;
                     end
                  end
               end
               ST_TX: begin
                  if (rise) begin
                     cnt_q <= cnt_q + 1'b1;
                     if (tx_ara_q && !oe_q && !sda_s) st_q <= ST_SKIP;
                  end else if (fall) begin
                     if (cnt_q == 4'd8) begin
                        oe_q  <= 1'b0;
                        st_q  <= ST_MACK;
                        won_q <= tx_ara_q;
                     end else begin
                        sh_q <= {sh_q[6:0], 1'b0};
                        oe_q <= ~sh_q[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (rise) begin
                     macked_q <= ~sda_s;
                  end else if (fall) begin
                     if (tx_ara_q) begin
                        st_q <= ST_SKIP;
                     end else begin
                        stat_q <= (cmd_q == C_STATUS);
                        if (macked_q) begin
                           sh_q  <= rd_data;
                           oe_q  <= ~rd_data[7];
                           cnt_q <= '0;
                           st_q  <= ST_TX;
                        end else begin
                           st_q <= ST_SKIP;
                        end
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign sda_oe   = oe_q;
   assign cmd_ptr  = cmd_q;
   assign wr_en    = wr_q;
   assign wr_data  = wdat_q;
   assign stat_acc = stat_q;
   assign ara_won  = won_q;

   // R2
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE) |-> !oe_q);

   // R10
   tmo_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |=> (!oe_q && st_q == ST_IDLE));

   // R8
   ara_won_chk: assert property (@(posedge clk) disable iff (!rst_n)
      won_q |-> (st_q == ST_MACK && !oe_q && tx_ara_q));

   // R9
   arb_lost_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_TX && tx_ara_q && rise && !oe_q && !sda_s && !tmo_hit && !start_ev && !stop_ev)
      |=> (st_q == ST_SKIP && !won_q));

endmodule

// File: rtl/cmon_regfile.sv
module cmon_regfile
   import cmon_smb_pkg::*;
#(
   parameter int         NCH  = 4,
   parameter logic [2:0] REV  = 3'd1,
   parameter logic [5:0] YEAR = 6'd13,
   parameter logic [5:0] WEEK = 6'd40
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [7:0]         rd_code,
   output logic [7:0]         rd_data,
   input  logic               wr_en,
   input  logic [7:0]         wr_code,
   input  logic [7:0]         wr_data,
   input  logic [7:0]         status_i,
   input  logic [NCH*8-1:0]   adc_i,
   output logic [7:0]         ctrl_o,
   output logic [7:0]         ocd_o,
   output logic [7:0]         sdd_o,
   output logic [MAX_CH*8-1:0] thr_o,
   output logic               wr_stb_o,
   output logic [3:0]         wr_code_o,
   output logic [7:0]         wr_data_o
);

   initial begin
      assert (NCH == 2 || NCH == 4) else $error("cmon_regfile: NCH must be 2 or 4");
   end

   logic [7:0] ctrl_q, ocd_q, sdd_q;
   logic [7:0] thr_q [MAX_CH];
   logic [7:0] adc_bank [MAX_CH];
   logic       stb_q;
   logic [3:0] stb_code_q;
   logic [7:0] stb_data_q;
   logic       wr_ok;

   for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
      if (g < NCH) begin : g_live
         assign adc_bank[g] = adc_i[8*g +: 8];
      end else begin : g_absent
         assign adc_bank[g] = 8'h00;
      end
      assign thr_o[8*g +: 8] = thr_q[g];
   end

   assign wr_ok = (wr_code inside {8'h00, 8'h01, 8'h02, 8'h03, 8'h08, 8'h09, 8'h0A, 8'h0B});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q     <= RST_CTRL;
         ocd_q      <= RST_OCD;
         sdd_q      <= RST_SDD;
         for (int i = 0; i < MAX_CH; i++) thr_q[i] <= RST_THR;
         stb_q      <= 1'b0;
         stb_code_q <= '0;
         stb_data_q <= '0;
      end else begin
         stb_q <= wr_en && wr_ok;
         if (wr_en && wr_ok) begin
            stb_code_q <= wr_code[3:0];
            stb_data_q <= wr_data;
         end
         if (wr_en) begin
            unique case (wr_code)
               C_CTRL: ctrl_q <= wr_data;
               C_OCD:  ocd_q  <= wr_data;
               C_SDD:  sdd_q  <= wr_data;
               8'h08, 8'h09, 8'h0A, 8'h0B: thr_q[wr_code[1:0]] <= wr_data;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      unique case (rd_code)
         C_STATUS: rd_data = status_i;
         C_CTRL:   rd_data = ctrl_q;
         C_OCD:    rd_data = ocd_q;
         C_SDD:    rd_data = sdd_q;
         8'h04, 8'h05, 8'h06, 8'h07: rd_data = adc_bank[rd_code[1:0]];
         8'h08, 8'h09, 8'h0A, 8'h0B: rd_data = thr_q[rd_code[1:0]];
         8'h0C:    rd_data = {5'b00001, REV};
         8'h0D:    rd_data = {2'b00, YEAR};
         8'h0E:    rd_data = {2'b00, WEEK};
         default:  rd_data = 8'hFF;
      endcase
   end

   assign ctrl_o    = ctrl_q;
   assign ocd_o     = ocd_q;
   assign sdd_o     = sdd_q;
   assign wr_stb_o  = stb_q;
   assign wr_code_o = stb_code_q;
   assign wr_data_o = stb_data_q;

   // R4
   ro_nostb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_code inside {8'h04, 8'h05, 8'h06, 8'h07, 8'h0C, 8'h0D, 8'h0E})) |=> !stb_q);

   // R4
   stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stb_q |-> $past(wr_en));

   // R4
   ocd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_code == C_OCD) |=> $stable(ocd_q));

endmodule

// File: rtl/cmon_smb_slave.sv
module cmon_smb_slave
   import cmon_smb_pkg::*;
#(
   parameter int         NCH         = 4,
   parameter int         TIMEOUT_CYC = 7_500_000,
   parameter int         SYNC_STAGES = 2,
   parameter logic [2:0] REV         = 3'd1,
   parameter logic [5:0] YEAR        = 6'd13,
   parameter logic [5:0] WEEK        = 6'd40
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic [6:0]       own_addr_i,
   input  logic             alert_req_i,
   input  logic [7:0]       status_i,
   input  logic [NCH*8-1:0] adc_i,
   output logic [7:0]       ctrl_o,
   output logic [7:0]       ocd_o,
   output logic [7:0]       sdd_o,
   output logic [31:0]      thr_o,
   output logic             wr_stb_o,
   output logic [3:0]       wr_code_o,
   output logic [7:0]       wr_data_o,
   output logic             stat_acc_o,
   output logic             ara_won_o
);

   logic [1:0] pin_s, pin_p;
   logic [7:0] cmd_ptr, rd_data, wr_data;
   logic       wr_en;
   logic       ara_armed;

   cmon_pin_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    ({scl_i, sda_i}),
      .sync_o (pin_s),
      .last_o (pin_p)
   );

   assign ara_armed = ctrl_o[ALERT_BIT] & alert_req_i;

   cmon_smb_fsm #(.TIMEOUT_CYC(TIMEOUT_CYC)) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (pin_s[1]),
      .scl_p     (pin_p[1]),
      .sda_s     (pin_s[0]),
      .sda_p     (pin_p[0]),
      .own_addr  (own_addr_i),
      .ara_armed (ara_armed),
      .rd_data   (rd_data),
      .sda_oe    (sda_oe_o),
      .cmd_ptr   (cmd_ptr),
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .stat_acc  (stat_acc_o),
      .ara_won   (ara_won_o)
   );

   cmon_regfile #(.NCH(NCH), .REV(REV), .YEAR(YEAR), .WEEK(WEEK)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_code   (cmd_ptr),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .wr_code   (cmd_ptr),
      .wr_data   (wr_data),
      .status_i  (status_i),
      .adc_i     (adc_i),
      .ctrl_o    (ctrl_o),
      .ocd_o     (ocd_o),
      .sdd_o     (sdd_o),
      .thr_o     (thr_o),
      .wr_stb_o  (wr_stb_o),
      .wr_code_o (wr_code_o),
      .wr_data_o (wr_data_o)
   );

endmodule

// File: tb/cmon_smb_slave_tb.sv
module cmon_smb_slave_tb_top;

   localparam int         QTR   = 5;
   localparam int         TMO   = 300;
   localparam logic [6:0] OWN   = 7'h34;
   localparam logic [6:0] RIVAL = 7'h30;

   // {write?, code, write data, expected read}
   localparam logic [24:0] VEC [14] = '{
      {1'b1, 8'h01, 8'h09, 8'h09},
      {1'b1, 8'h02, 8'h85, 8'h85},
      {1'b1, 8'h03, 8'h7F, 8'h7F},
      {1'b1, 8'h08, 8'h10, 8'h10},
      {1'b1, 8'h0B, 8'hFF, 8'hFF},
      {1'b1, 8'h0A, 8'h3C, 8'h3C},
      {1'b1, 8'h05, 8'h00, 8'hA2},
      {1'b1, 8'h0C, 8'h00, 8'h0D},
      {1'b0, 8'h0D, 8'h00, 8'h14},
      {1'b0, 8'h0E, 8'h00, 8'h2B},
      {1'b0, 8'h04, 8'h00, 8'h5C},
      {1'b0, 8'h06, 8'h00, 8'h00},
      {1'b0, 8'h07, 8'h00, 8'h00},
      {1'b0, 8'h00, 8'h00, 8'h35}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl_m = 1'b1, sda_m = 1'b1;
   logic        rival_on = 1'b0, rival_low = 1'b0;
   logic [7:0]  rival_b = {RIVAL, 1'b1};
   logic        alert_req = 1'b0;
   logic [7:0]  status = 8'h35;
   logic [15:0] adc = {8'hA2, 8'h5C};
   logic        sda_oe;
   logic        sda_line;
   logic [7:0]  ctrl, ocd, sdd, wr_data;
   logic [31:0] thr;
   logic        wr_stb, stat_acc, ara_won;
   logic [3:0]  wr_code;

   int n_tests = 0, n_fail = 0;
   int stb_cnt = 0, stat_cnt = 0, won_cnt = 0;
   logic [3:0] last_code;
   logic [7:0] last_data;
   bit done = 0;

   always #2 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe & ~rival_low;

   cmon_smb_slave #(
      .NCH(2), .TIMEOUT_CYC(TMO), .REV(3'd5), .YEAR(6'd20), .WEEK(6'd43)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
      .own_addr_i(OWN), .alert_req_i(alert_req), .status_i(status), .adc_i(adc),
      .ctrl_o(ctrl), .ocd_o(ocd), .sdd_o(sdd), .thr_o(thr),
      .wr_stb_o(wr_stb), .wr_code_o(wr_code), .wr_data_o(wr_data),
      .stat_acc_o(stat_acc), .ara_won_o(ara_won)
   );

   always @(negedge clk) begin
      if (wr_stb) begin
         stb_cnt++;
         last_code = wr_code;
         last_data = wr_data;
      end
      if (stat_acc) stat_cnt++;
      if (ara_won) won_cnt++;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic qw();
      repeat (QTR) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw(); qw();
   endtask

   task automatic clk_bit(input logic b, output logic r);
      sda_m = b; qw(); scl_m = 1'b1; qw(); r = sda_line; qw(); scl_m = 1'b0; qw();
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
      clk_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic recv_byte(input logic mack, output logic [7:0] b);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         rival_low = rival_on & ~rival_b[i];
         clk_bit(1'b1, r);
         b[i] = r;
      end
      rival_low = 1'b0;
      clk_bit(~mack, r);
   endtask

   task automatic wr_byte(input logic [7:0] code, input logic [7:0] d, output logic ok);
      logic a1, a2, a3;
      bus_start();
      send_byte({OWN, 1'b0}, a1);
      send_byte(code, a2);
      send_byte(d, a3);
      bus_stop();
      ok = a1 & a2 & a3;
   endtask

   task automatic rd_byte(input logic [7:0] code, output logic [7:0] d, output logic cack, output logic aok);
      logic a1, a2;
      bus_start();
      send_byte({OWN, 1'b0}, a1);
      send_byte(code, cack);
      bus_start();
      send_byte({OWN, 1'b1}, a2);
      recv_byte(1'b0, d);
      bus_stop();
      aok = a1 & a2;
   endtask

   task automatic rx_byte(output logic [7:0] d, output logic ok);
      bus_start();
      send_byte({OWN, 1'b1}, ok);
      recv_byte(1'b0, d);
      bus_stop();
   endtask

   task automatic ara_read(output logic ack, output logic [7:0] d);
      bus_start();
      send_byte({7'h0C, 1'b1}, ack);
      if (ack) recv_byte(1'b0, d);
      else d = 8'h00;
      bus_stop();
   endtask

   function automatic logic strobed(input logic [7:0] c);
      return (c == 8'h00) || (c >= 8'h01 && c <= 8'h03) || (c >= 8'h08 && c <= 8'h0B);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic ok, ok2;
      logic [7:0] d;
      int s0, w0;

      repeat (10) @(negedge clk);
      rst_n = 1'b1;
      repeat (10) @(negedge clk);

      // R1 reset values
      check("R1 ctrl", ctrl, 8'h0C);
      check("R1 ocd", ocd, 8'h04);
      check("R1 sdd", sdd, 8'h14);
      check("R1 thr", thr, 32'hD1D1D1D1);
      check("R1 sda", sda_oe, 1'b0);

      // R1 R6 bare receive byte returns status; R7 status read pulse
      rx_byte(d, ok);
      check("R1 rx ack", ok, 1'b1);
      check("R1 rx status", d, 8'h35);
      check("R7 rx pulse", stat_cnt, 1);

      // R4 R5 vector table
      foreach (VEC[k]) begin
         logic [7:0] code, wd, ex;
         code = VEC[k][23:16];
         wd   = VEC[k][15:8];
         ex   = VEC[k][7:0];
         if (VEC[k][24]) begin
            s0 = stb_cnt;
            wr_byte(code, wd, ok);
            check("R4 write ack", ok, 1'b1);
            if (strobed(code)) begin
               check("R4 strobe count", stb_cnt, s0 + 1);
               check("R4 strobe code", last_code, code[3:0]);
               check("R4 strobe data", last_data, wd);
            end else begin
               check("R4 ro no strobe", stb_cnt, s0);
            end
         end
         rd_byte(code, d, ok, ok2);
         check("R5 read ack", ok & ok2, 1'b1);
         check("R5 read data", d, ex);
      end
      check("R4 thr map", thr, 32'hFF3CD110);

      // R3 invalid command
      wr_byte(8'h20, 8'h55, ok);
      check("R3 invalid nack", ok, 1'b0);
      rd_byte(8'h0F, d, ok, ok2);
      check("R3 invalid cmd nack", ok, 1'b0);
      check("R3 invalid read FF", d, 8'hFF);
      rx_byte(d, ok);
      check("R6 rx invalid FF", d, 8'hFF);
      rd_byte(8'h02, d, ok, ok2);
      rx_byte(d, ok);
      check("R6 rx last code", d, 8'h85);

      // R2 foreign and general call addresses
      bus_start(); send_byte(8'h00, ok); bus_stop();
      check("R2 general call nack", ok, 1'b0);
      bus_start(); send_byte({7'h33, 1'b0}, ok); bus_stop();
      check("R2 other addr nack", ok, 1'b0);

      // R7 R4 status write
      s0 = stb_cnt; w0 = stat_cnt;
      wr_byte(8'h00, 8'h0F, ok);
      check("R4 status strobe", stb_cnt, s0 + 1);
      check("R4 status strobe code", last_code, 4'h0);
      check("R7 status write pulse", stat_cnt, w0 + 1);
      rd_byte(8'h00, d, ok, ok2);
      check("R7 status read pulse", stat_cnt, w0 + 2);

      // R8 alert response
      ara_read(ok, d);
      check("R8 ara no request nack", ok, 1'b0);
      alert_req = 1'b1;
      wr_byte(8'h01, 8'h04, ok);
      ara_read(ok, d);
      check("R8 ara disabled nack", ok, 1'b0);
      wr_byte(8'h01, 8'h0C, ok);
      w0 = won_cnt;
      ara_read(ok, d);
      check("R8 ara ack", ok, 1'b1);
      check("R8 ara byte", d, {OWN, 1'b1});
      check("R8 ara won", won_cnt, w0 + 1);

      // R9 lost arbitration to lower address
      rival_on = 1'b1;
      w0 = won_cnt;
      ara_read(ok, d);
      rival_on = 1'b0;
      check("R9 line carries rival", d, {RIVAL, 1'b1});
      check("R9 no win", won_cnt, w0);
      ara_read(ok, d);
      check("R9 retry wins", won_cnt, w0 + 1);

      // R10 clock low timeout
      begin
         logic r;
         logic [7:0] a;
         a = {OWN, 1'b0};
         bus_start();
         for (int i = 7; i >= 0; i--) clk_bit(a[i], r);
         repeat (10) @(negedge clk);
         check("R10 acking before timeout", sda_oe, 1'b1);
         repeat (TMO + 20) @(negedge clk);
         check("R10 released after timeout", sda_oe, 1'b0);
         bus_stop();
      end
      rd_byte(8'h01, d, ok, ok2);
      check("R10 recovery read", d, 8'h0C);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule